// File: doc/BRIEF.md
# Machine-Mode Trap and CSR Unit

This block manages trap entry and trap return for a small 32-bit processor core that runs only in machine mode. It holds the trap control registers: a global interrupt enable with a saved copy, per-source interrupt enables, the handler base with its mode field, the saved exception address, and the trap cause. The pipeline reports a synchronous fault with a code and the PC of the faulting instruction. Three interrupt lines (software, timer, external) come straight from their sources. A return strobe marks the return-from-trap instruction.

Each cycle the block picks at most one event. It updates its registers and, one cycle later, shows a one-cycle redirect strobe with the new fetch address. Software reads the registers through a combinational read port and writes them through a single-cycle write strobe. The saved address is the address of the trapping instruction itself. A handler that returns past an environment call must therefore add 4 to it before it returns.

Top module: `mtrap_unit`

## Requirements
- R1: After reset, `redir_valid` is 0 and every readable register (status, enables, base, saved address, cause) reads 0.
- R2: When `exc_req` is 1, the next cycle shows `redir_valid`=1 with `redir_pc` = base register with bits [1:0] cleared, in every mode. The cause register becomes bit 31 = 0 and bits [4:0] = `exc_code` (0 to 7 and 11 are the defined codes; 11 is an environment call).
- R3: An interrupt is taken only when the global enable (status bit 3) and the source's enable bit are both 1. Source enable bits are 3 for software, 7 for timer and 11 for external. The cause becomes bit 31 = 1 with code 3 (software), 7 (timer) or 11 (external).
- R4: When several enabled interrupts are pending together, external wins over software, which wins over timer. A synchronous exception in the same cycle wins over any interrupt.
- R5: Base register bits [1:0] hold the mode. When the mode is 1, an interrupt redirects to base + 4 × code. Modes 0, 2 and 3, and all synchronous exceptions, redirect to the base.
- R6: On trap entry, the saved-address register receives `trap_pc` unchanged, with no +4. Otherwise it changes only on a software write to it.
- R7: On trap entry, the saved-enable bit (status bit 7) takes the old global enable and the global enable becomes 0.
- R8: When `ret_req` is 1 and no trap is taken, the next cycle shows `redir_valid`=1 with `redir_pc` = the saved address. The global enable takes the saved-enable bit and the saved-enable bit becomes 1.
- R9: If a trap and a software write happen in the same cycle, the trap's updates of status, saved address and cause win, and writes to the base or enable registers still take effect. The redirect uses the base as it was before the write. A trap in the same cycle as `ret_req` makes the return have no effect.
- R10: Register addresses are 0x300 status, 0x304 enables, 0x305 base, 0x341 saved address, 0x342 cause, and 0x344 pending (read-only raw lines at bits 3/7/11). The status register exposes only bits 3 and 7; other addresses read 0 and writes to them are ignored.
- R11: `redir_valid` is 1 only in the cycle after a trap or an accepted return; it is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_req | input | 1 | Synchronous exception request from pipeline |
| exc_code | input | 5 | Exception code |
| trap_pc | input | 32 | PC of the instruction at the trap point |
| irq_soft | input | 1 | Software interrupt line |
| irq_timer | input | 1 | Timer interrupt line |
| irq_ext | input | 1 | External interrupt line |
| ret_req | input | 1 | Return-from-trap strobe |
| csr_wr | input | 1 | Register write strobe |
| csr_addr | input | 12 | Register address |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data (combinational) |
| redir_valid | output | 1 | Redirect strobe |
| redir_pc | output | 32 | Redirect target |

## Verification
The focus is trap entry landing in the same cycle as a software register write or a return strobe. In that case the event and the write compete for the status, saved-address and cause registers. Directed cycles pair a fault with a write to the saved address, and a fault with a write to the base. They also pair a fault with a return strobe. Random cycles mix all strobes freely. A bench model orders the updates as the requirements state, so each case is judged by the redirect target in the next cycle and by read-back of every register.

// File: rtl/mtrap_pkg.sv
package mtrap_pkg;
  localparam int CODE_W = 5;
  localparam int NSRC   = 3;

  localparam logic [11:0] A_STATUS = 12'h300;
  localparam logic [11:0] A_IE     = 12'h304;
  localparam logic [11:0] A_TVEC   = 12'h305;
  localparam logic [11:0] A_EPC    = 12'h341;
  localparam logic [11:0] A_CAUSE  = 12'h342;
  localparam logic [11:0] A_PEND   = 12'h344;

  localparam int GIE_BIT = 3;
  localparam int SAV_BIT = 7;

  // source index 0 has the highest priority: external, software, timer
  localparam int SRC_LINE [NSRC] = '{11, 3, 7};

  localparam logic [1:0] MODE_VEC = 2'd1;

  typedef struct packed {
    logic              take;
    logic              irq;
    logic [CODE_W-1:0] code;
  } trap_sel_t;
endpackage

// File: rtl/mtrap_arb.sv
module mtrap_arb
  import mtrap_pkg::*;
(
  input  logic              exc_req,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              gie,
  input  logic [NSRC-1:0]   src_en,
  input  logic [NSRC-1:0]   src_pend,
  output trap_sel_t         sel
);
  logic [NSRC-1:0] armed;

  assign armed = src_en & src_pend & {NSRC{gie}};

  always_comb begin
    sel = '0;
    // scan from lowest priority so the highest armed source is written last
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (armed[i]) begin
        sel.take = 1'b1;
        sel.irq  = 1'b1;
        sel.code = CODE_W'(SRC_LINE[i]);
      end
    end
    if (exc_req) begin
      sel.take = 1'b1;
      sel.irq  = 1'b0;
      sel.code = exc_code;
    end
  end
endmodule

// File: rtl/mtrap_target.sv
module mtrap_target
  import mtrap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0]   tvec,
  input  logic              is_irq,
  input  logic [CODE_W-1:0] code,
  output logic [XLEN-1:0]   target
);
  localparam int OFFS_W = CODE_W + 2;

  logic [XLEN-1:0] base;
  logic [XLEN-1:0] offs;
  logic            use_vec;

  assign base    = {tvec[XLEN-1:2], 2'b00};
  assign offs    = {{(XLEN-OFFS_W){1'b0}}, code, 2'b00};
  assign use_vec = is_irq && (tvec[1:0] == MODE_VEC);
  assign target  = use_vec ? (base + offs) : base;
endmodule

// File: rtl/mtrap_csr.sv
module mtrap_csr
  import mtrap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            csr_wr,
  input  logic [11:0]     csr_addr,
  input  logic [XLEN-1:0] csr_wdata,
  input  logic [NSRC-1:0] src_pend,
  input  trap_sel_t       sel,
  input  logic [XLEN-1:0] trap_pc,
  input  logic            ret_req,
  output logic            gie,
  output logic [NSRC-1:0] src_en,
  output logic [XLEN-1:0] tvec,
  output logic [XLEN-1:0] epc,
  output logic [XLEN-1:0] cause,
  output logic [XLEN-1:0] rdata
);
  localparam int PAD_W = XLEN - 1 - CODE_W;

  logic gie_q, sav_q, gie_n, sav_n, st_ld;
  logic [XLEN-1:0] tvec_q, epc_q, cause_q;
  logic [XLEN-1:0] epc_n, cause_n;
  logic epc_ld, cause_ld;
  logic wr_status, wr_ie, wr_tvec, wr_epc, wr_cause;
  logic [XLEN-1:0] st_view, ie_view, pend_view;

  // write decode
  assign wr_status = csr_wr && (csr_addr == A_STATUS);
  assign wr_ie     = csr_wr && (csr_addr == A_IE);
  assign wr_tvec   = csr_wr && (csr_addr == A_TVEC);
  assign wr_epc    = csr_wr && (csr_addr == A_EPC);
  assign wr_cause  = csr_wr && (csr_addr == A_CAUSE);

  // status next state: trap beats return beats software write
  always_comb begin
    gie_n = gie_q;
    sav_n = sav_q;
    if (wr_status) begin
      gie_n = csr_wdata[GIE_BIT];
      sav_n = csr_wdata[SAV_BIT];
    end
    if (sel.take) begin
      sav_n = gie_q;
      gie_n = 1'b0;
    end else if (ret_req) begin
      gie_n = sav_q;
      sav_n = 1'b1;
    end
    st_ld = wr_status | sel.take | ret_req;
  end

  // saved address and cause next state
  always_comb begin
    epc_n    = sel.take ? trap_pc : csr_wdata;
    epc_ld   = sel.take | wr_epc;
    cause_n  = sel.take ? {sel.irq, {PAD_W{1'b0}}, sel.code} : csr_wdata;
    cause_ld = sel.take | wr_cause;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q <= 1'b0;
      sav_q <= 1'b0;
    end else if (st_ld) begin
      gie_q <= gie_n;
      sav_q <= sav_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tvec_q <= '0;
    else if (wr_tvec) tvec_q <= csr_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) epc_q <= '0;
    else if (epc_ld) epc_q <= epc_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause_q <= '0;
    else if (cause_ld) cause_q <= cause_n;
  end

  // one enable flop per interrupt source
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic en_q, en_n;
    assign en_n = csr_wdata[SRC_LINE[i]];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= 1'b0;
      else if (wr_ie) en_q <= en_n;
    end
    assign src_en[i] = en_q;
  end

  // read views
  always_comb begin
    st_view   = '0;
    ie_view   = '0;
    pend_view = '0;
    st_view[GIE_BIT] = gie_q;
    st_view[SAV_BIT] = sav_q;
    for (int i = 0; i < NSRC; i++) begin
      ie_view[SRC_LINE[i]]   = src_en[i];
      pend_view[SRC_LINE[i]] = src_pend[i];
    end
  end

  always_comb begin
    case (csr_addr)
      A_STATUS: rdata = st_view;
      A_IE:     rdata = ie_view;
      A_TVEC:   rdata = tvec_q;
      A_EPC:    rdata = epc_q;
      A_CAUSE:  rdata = cause_q;
      A_PEND:   rdata = pend_view;
      default:  rdata = '0;
    endcase
  end

  assign gie   = gie_q;
  assign tvec  = tvec_q;
  assign epc   = epc_q;
  assign cause = cause_q;

  // R7
  trap_clears_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel.take |=> (!gie_q && (sav_q == $past(gie_q))));
  // R8
  ret_restores_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && !sel.take) |=> (sav_q && (gie_q == $past(sav_q))));
  // R6
  epc_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel.take |=> (epc_q == $past(trap_pc)));
  // R6
  epc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel.take && !wr_epc) |=> $stable(epc_q));
endmodule

// File: rtl/mtrap_unit.sv
module mtrap_unit
  import mtrap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_req,
  input  logic [CODE_W-1:0] exc_code,
  input  logic [XLEN-1:0]   trap_pc,
  input  logic              irq_soft,
  input  logic              irq_timer,
  input  logic              irq_ext,
  input  logic              ret_req,
  input  logic              csr_wr,
  input  logic [11:0]       csr_addr,
  input  logic [XLEN-1:0]   csr_wdata,
  output logic [XLEN-1:0]   csr_rdata,
  output logic              redir_valid,
  output logic [XLEN-1:0]   redir_pc
);
  trap_sel_t       sel;
  logic            gie;
  logic [NSRC-1:0] src_en, src_pend;
  logic [XLEN-1:0] tvec, epc, cause, target;
  logic            rv_q, rv_n;
  logic [XLEN-1:0] rpc_q, rpc_n;

  assign src_pend = {irq_timer, irq_soft, irq_ext};

  mtrap_arb u_arb (
    .exc_req  (exc_req),
    .exc_code (exc_code),
    .gie      (gie),
    .src_en   (src_en),
    .src_pend (src_pend),
    .sel      (sel)
  );

  mtrap_target #(.XLEN(XLEN)) u_target (
    .tvec   (tvec),
    .is_irq (sel.irq),
    .code   (sel.code),
    .target (target)
  );

  mtrap_csr #(.XLEN(XLEN)) u_csr (
    .clk       (clk),
    .rst_n     (rst_n),
    .csr_wr    (csr_wr),
    .csr_addr  (csr_addr),
    .csr_wdata (csr_wdata),
    .src_pend  (src_pend),
    .sel       (sel),
    .trap_pc   (trap_pc),
    .ret_req   (ret_req),
    .gie       (gie),
    .src_en    (src_en),
    .tvec      (tvec),
    .epc       (epc),
    .cause     (cause),
    .rdata     (csr_rdata)
  );

  // redirect next state
  always_comb begin
    rv_n  = sel.take | ret_req;
    rpc_n = sel.take ? target : epc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q  <= 1'b0;
      rpc_q <= '0;
    end else begin
      rv_q <= rv_n;
      if (rv_n) rpc_q <= rpc_n;
    end
  end

  assign redir_valid = rv_q;
  assign redir_pc    = rpc_q;

  // R11
  redir_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel.take && !ret_req) |=> !redir_valid);
  // R8
  ret_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && !sel.take) |=> (redir_valid && (redir_pc == $past(epc))));
  // R4
  exc_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |=> (redir_valid && !cause[XLEN-1]));
  // R2
  exc_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |=> (redir_pc == {$past(tvec[XLEN-1:2]), 2'b00}));
  // R3
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel.take && sel.irq) |=> cause[XLEN-1]);
endmodule

// File: tb/mtrap_unit_test.sv
`timescale 1ns/1ps
module mtrap_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        exc_req, irq_soft, irq_timer, irq_ext, ret_req, csr_wr;
  logic [4:0]  exc_code;
  logic [31:0] trap_pc, csr_wdata, csr_rdata, redir_pc;
  logic [11:0] csr_addr;
  logic        redir_valid;

  int total = 0;
  int bad   = 0;

  // bench model of the architectural state
  bit          m_gie, m_sav;
  bit [2:0]    m_en;          // 0 external, 1 software, 2 timer
  logic [31:0] m_tvec, m_epc, m_cause;

  always #4 clk = ~clk;

  mtrap_unit uut (
    .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_code(exc_code),
    .trap_pc(trap_pc), .irq_soft(irq_soft), .irq_timer(irq_timer),
    .irq_ext(irq_ext), .ret_req(ret_req), .csr_wr(csr_wr),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .redir_valid(redir_valid), .redir_pc(redir_pc)
  );

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [11:0] a, input bit sw, input bit tm, input bit ex);
    logic [31:0] r;
    r = '0;
    case (a)
      12'h300: begin r[3] = m_gie; r[7] = m_sav; end
      12'h304: begin r[11] = m_en[0]; r[3] = m_en[1]; r[7] = m_en[2]; end
      12'h305: r = m_tvec;
      12'h341: r = m_epc;
      12'h342: r = m_cause;
      12'h344: begin r[11] = ex; r[3] = sw; r[7] = tm; end
      default: r = '0;
    endcase
    return r;
  endfunction

  // one clock cycle: drive at negedge, check read port, model the edge, check redirect
  task automatic cyc(input bit ex, input logic [4:0] code, input logic [31:0] pc,
                     input bit sw, input bit tm, input bit ext, input bit ret,
                     input bit wr, input logic [11:0] a, input logic [31:0] d,
                     input string tag);
    bit a_ext, a_sw, a_tm, irq, e_rv;
    logic [4:0]  icode;
    logic [31:0] base, e_rpc;
    bit n_gie, n_sav;
    bit [2:0] n_en;
    logic [31:0] n_tvec, n_epc, n_cause;
    exc_req = ex; exc_code = code; trap_pc = pc;
    irq_soft = sw; irq_timer = tm; irq_ext = ext; ret_req = ret;
    csr_wr = wr; csr_addr = a; csr_wdata = d;
    #1;
    chk({tag, " rdata"}, csr_rdata, m_read(a, sw, tm, ext));
    a_ext = m_gie & m_en[0] & ext;
    a_sw  = m_gie & m_en[1] & sw;
    a_tm  = m_gie & m_en[2] & tm;
    irq   = a_ext | a_sw | a_tm;
    icode = a_ext ? 5'd11 : (a_sw ? 5'd3 : 5'd7);
    base  = {m_tvec[31:2], 2'b00};
    n_gie = m_gie; n_sav = m_sav; n_en = m_en;
    n_tvec = m_tvec; n_epc = m_epc; n_cause = m_cause;
    if (wr) begin
      case (a)
        12'h300: begin n_gie = d[3]; n_sav = d[7]; end
        12'h304: n_en = {d[7], d[3], d[11]};
        12'h305: n_tvec = d;
        12'h341: n_epc = d;
        12'h342: n_cause = d;
        default: ;
      endcase
    end
    e_rv = 1'b1;
    e_rpc = 32'h0;
    if (ex) begin
      e_rpc = base;
      n_cause = {27'b0, code};
      n_epc = pc; n_sav = m_gie; n_gie = 1'b0;
    end else if (irq) begin
      e_rpc = (m_tvec[1:0] == 2'd1) ? base + {25'b0, icode, 2'b00} : base;
      n_cause = {1'b1, 26'b0, icode};
      n_epc = pc; n_sav = m_gie; n_gie = 1'b0;
    end else if (ret) begin
      e_rpc = m_epc; n_gie = m_sav; n_sav = 1'b1;
    end else begin
      e_rv = 1'b0;
    end
    @(posedge clk);
    m_gie = n_gie; m_sav = n_sav; m_en = n_en;
    m_tvec = n_tvec; m_epc = n_epc; m_cause = n_cause;
    @(negedge clk);
    chk({tag, " redir_valid"}, {31'b0, redir_valid}, {31'b0, e_rv});
    if (e_rv) chk({tag, " redir_pc"}, redir_pc, e_rpc);
  endtask

  task automatic idle(input string tag);
    cyc(0, 5'd0, 32'h0, 0, 0, 0, 0, 0, 12'h000, 32'h0, tag);
  endtask

  task automatic wr_reg(input logic [11:0] a, input logic [31:0] d, input string tag);
    cyc(0, 5'd0, 32'h0, 0, 0, 0, 0, 1, a, d, tag);
  endtask

  task automatic rd_reg(input logic [11:0] a, input logic [31:0] exp, input string tag);
    cyc(0, 5'd0, 32'h0, 0, 0, 0, 0, 0, a, 32'h0, tag);
    csr_addr = a;
    #1;
    chk({tag, " direct"}, csr_rdata, exp);
  endtask

  task automatic do_ret(input string tag);
    cyc(0, 5'd0, 32'h0, 0, 0, 0, 1, 0, 12'h000, 32'h0, tag);
  endtask

  // watchdog
  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    bit ex, sw, tm, ext, ret, wr;
    logic [4:0]  code;
    logic [11:0] a;
    void'($urandom(32'd7321));
    rst_n = 1'b0;
    exc_req = 0; exc_code = 0; trap_pc = 0; irq_soft = 0; irq_timer = 0;
    irq_ext = 0; ret_req = 0; csr_wr = 0; csr_addr = 0; csr_wdata = 0;
    m_gie = 0; m_sav = 0; m_en = 0; m_tvec = 0; m_epc = 0; m_cause = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 redir_valid", {31'b0, redir_valid}, 32'h0);
    foreach (m_en[i]) begin end
    csr_addr = 12'h300; #1; chk("R1 status", csr_rdata, 32'h0);
    csr_addr = 12'h304; #1; chk("R1 enables", csr_rdata, 32'h0);
    csr_addr = 12'h305; #1; chk("R1 base", csr_rdata, 32'h0);
    csr_addr = 12'h341; #1; chk("R1 epc", csr_rdata, 32'h0);
    csr_addr = 12'h342; #1; chk("R1 cause", csr_rdata, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 register map
    wr_reg(12'h305, 32'h0000_1000, "R10");
    wr_reg(12'h304, 32'hFFFF_FFFF, "R10");
    wr_reg(12'h300, 32'h0000_0008, "R10");
    rd_reg(12'h304, 32'h0000_0888, "R10");
    rd_reg(12'h300, 32'h0000_0008, "R10");
    wr_reg(12'h344, 32'hFFFF_FFFF, "R10");
    rd_reg(12'h344, 32'h0, "R10");
    rd_reg(12'h7C0, 32'h0, "R10");

    // R2 environment call, R6 no +4, R7 enable saved
    cyc(1, 5'd11, 32'h0000_0200, 0, 0, 0, 0, 0, 12'h000, 32'h0, "R2");
    chk("R2 target", redir_pc, 32'h0000_1000);
    rd_reg(12'h342, 32'h0000_000B, "R2");
    rd_reg(12'h341, 32'h0000_0200, "R6");
    rd_reg(12'h300, 32'h0000_0080, "R7");
    // R3 external pending while globally disabled
    cyc(0, 5'd0, 32'h300, 0, 0, 1, 0, 0, 12'h000, 32'h0, "R3");
    chk("R3 masked", {31'b0, redir_valid}, 32'h0);
    idle("R6");
    rd_reg(12'h341, 32'h0000_0200, "R6");
    // R8 return
    do_ret("R8");
    chk("R8 target", redir_pc, 32'h0000_0200);
    rd_reg(12'h300, 32'h0000_0088, "R8");

    // R4/R5 vectored priority
    wr_reg(12'h305, 32'h0000_1001, "R5");
    cyc(0, 5'd0, 32'h400, 1, 1, 1, 0, 0, 12'h000, 32'h0, "R4");
    chk("R5 ext vec", redir_pc, 32'h0000_102C);
    rd_reg(12'h342, 32'h8000_000B, "R3");
    do_ret("R8");
    cyc(0, 5'd0, 32'h404, 1, 1, 0, 0, 0, 12'h000, 32'h0, "R4");
    chk("R4 sw over tmr", redir_pc, 32'h0000_100C);
    do_ret("R8");
    cyc(0, 5'd0, 32'h408, 0, 1, 0, 0, 0, 12'h000, 32'h0, "R5");
    chk("R5 tmr vec", redir_pc, 32'h0000_101C);
    do_ret("R8");
    cyc(1, 5'd2, 32'h40C, 1, 1, 1, 0, 0, 12'h000, 32'h0, "R4");
    chk("R4 exc over irq", redir_pc, 32'h0000_1000);
    rd_reg(12'h342, 32'h0000_0002, "R4");
    do_ret("R8");
    wr_reg(12'h305, 32'h0000_1002, "R5");
    cyc(0, 5'd0, 32'h410, 0, 1, 0, 0, 0, 12'h000, 32'h0, "R5");
    chk("R5 mode2 direct", redir_pc, 32'h0000_1000);
    do_ret("R8");

    // R3 per-source gating
    wr_reg(12'h304, 32'h0000_0008, "R3");
    cyc(0, 5'd0, 32'h500, 0, 1, 1, 0, 0, 12'h000, 32'h0, "R3");
    chk("R3 src gate", {31'b0, redir_valid}, 32'h0);
    wr_reg(12'h304, 32'h0000_0888, "R3");

    // R9 same-cycle collisions
    cyc(1, 5'd3, 32'h600, 0, 0, 0, 0, 1, 12'h341, 32'hDEAD_0000, "R9");
    rd_reg(12'h341, 32'h0000_0600, "R9");
    do_ret("R8");
    cyc(1, 5'd1, 32'h604, 0, 0, 0, 0, 1, 12'h305, 32'h0000_2000, "R9");
    chk("R9 old base", redir_pc, 32'h0000_1000);
    rd_reg(12'h305, 32'h0000_2000, "R9");
    cyc(1, 5'd4, 32'h608, 0, 0, 0, 1, 0, 12'h000, 32'h0, "R9");
    chk("R9 trap over ret", redir_pc, 32'h0000_2000);
    rd_reg(12'h300, 32'h0000_0000, "R9");
    idle("R11");
    chk("R11 idle", {31'b0, redir_valid}, 32'h0);

    // constrained random
    for (int n = 0; n < 3000; n++) begin
      ex  = ($urandom % 10) == 0;
      case ($urandom % 9)
        0: code = 5'd0; 1: code = 5'd1; 2: code = 5'd2; 3: code = 5'd3;
        4: code = 5'd4; 5: code = 5'd5; 6: code = 5'd6; 7: code = 5'd7;
        default: code = 5'd11;
      endcase
      sw  = ($urandom % 5) == 0;
      tm  = ($urandom % 5) == 0;
      ext = ($urandom % 6) == 0;
      ret = ($urandom % 6) == 0;
      wr  = ($urandom % 4) == 0;
      case ($urandom % 7)
        0: a = 12'h300; 1: a = 12'h304; 2: a = 12'h305; 3: a = 12'h341;
        4: a = 12'h342; 5: a = 12'h344; default: a = 12'h7C0;
      endcase
      cyc(ex, code, $urandom, sw, tm, ext, ret, wr, a, $urandom, "R11");
    end

    summary();
    $finish;
  end
endmodule